// File: doc/BRIEF.md
# Logic Analyzer Trigger and Capture

This block watches sixteen digital channels, one sample per clock, and waits for a programmable trigger. In edge mode, one chosen channel must make a rising or falling transition. In pattern mode, every channel carries its own condition, and the trigger is the AND of all of them in one sample. When the trigger fires, the block records a fixed-length frame that starts with the trigger sample. It then offers the frame, oldest first, on a valid/ready read stream.

A run command re-arms the block after every frame, once a programmable holdoff has passed. A single command stops after one frame. A stop command halts the sequence and keeps a finished frame. A clear command discards the frame. Configuration is plain level inputs that are read live. Commands are one-cycle pulses.

The read stream follows valid/ready rules. A beat transfers on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_last` hold steady. The stream opens when a frame completes and closes after the beat flagged `rd_last`. A new trigger, a stop during capture, or a clear ends the stream at once, because the buffer is about to be rewritten or is discarded. In run mode the reader therefore has the holdoff window, plus the time until the next trigger, to drain the frame.

Top module: `la_trigger_capture`

## Requirements
- R1: After reset the block is idle: `armed`, `done`, `rd_valid` and `rd_last` are all 0.
- R2: In edge mode (`cfg_pattern_mode`=0), the trigger fires when channel `cfg_edge_src` changes between the previous and the current sample. With `cfg_edge_falling`=0 the change must be 0 to 1; with `cfg_edge_falling`=1 it must be 1 to 0. Other channels have no effect.
- R3: In pattern mode (`cfg_pattern_mode`=1), channel i takes a 3-bit code from `cfg_cond[3i+2:3i]`: 000 ignore, 001 low, 010 high, 011 rising, 100 falling. Codes 101 to 111 act as ignore. The trigger fires only when every channel meets its code in the same sample, so an all-ignore setting fires on every armed sample.
- R4: Rising and falling conditions cannot fire on the first armed sample, because the history of the previous sample is invalid at that point.
- R5: A frame holds 256 samples. Index 0 is the sample of the trigger cycle, and indices 1 to 255 are the following consecutive samples. `done` goes high on the edge that writes index 255. The next trigger clears `done`.
- R6: The read stream delivers indices 0 to 255 in order. `rd_last` is set on index 255, and the stream closes after that beat. Data holds under back-pressure.
- R7: After a frame in run mode, the block re-arms `cfg_holdoff`+1 cycles after the last write, so a value of 0 gives the minimum wait of one cycle. No trigger is taken during the holdoff.
- R8: Run mode re-arms after every frame. Single mode returns to idle after one frame.
- R9: A stop command returns the block to idle in the next cycle. A stop during capture leaves `done` at 0. A stop while armed or in holdoff keeps a finished frame and its stream.
- R10: A clear command returns the block to idle, lowers `done` and closes the stream. A later run or single command starts a fresh capture.
- R11: Run and single commands are taken only while idle. Within one cycle, clear wins over stop, stop over run, and run over single.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_in | input | 16 | Digital channel samples |
| cfg_pattern_mode | input | 1 | 0 selects edge mode, 1 selects pattern mode |
| cfg_edge_src | input | 4 | Edge-mode source channel |
| cfg_edge_falling | input | 1 | Edge-mode polarity, 1 selects falling |
| cfg_cond | input | 48 | Per-channel 3-bit pattern codes |
| cfg_holdoff | input | 16 | Holdoff length in cycles, minus one |
| cmd_run | input | 1 | Pulse: arm in repeating mode |
| cmd_single | input | 1 | Pulse: arm for one frame |
| cmd_stop | input | 1 | Pulse: halt and go idle |
| cmd_clear | input | 1 | Pulse: discard frame and go idle |
| armed | output | 1 | Waiting for a trigger |
| done | output | 1 | A complete frame is stored |
| rd_valid | output | 1 | Read stream beat available |
| rd_ready | input | 1 | Read stream consumer ready |
| rd_data | output | 16 | Captured sample at the current read index |
| rd_last | output | 1 | Current beat is index 255 |

## Verification
A command on edge E shows on `armed` right after E. A trigger sample at edge T clears `armed` right after T. `done` and `rd_valid` rise right after T+255. With holdoff H, `armed` returns right after T+256+H. The bench drives inputs on the falling clock edge, advances by whole cycles, and compares every output on the falling edge that follows the rising edge where the result is due. It also checks the cycle just before each due edge, so a result that arrives one cycle early is caught as well as one that arrives late. Read beats are checked at the falling edge after each accepting rising edge, and one beat is held under back-pressure for a full cycle.

// File: rtl/la_pkg.sv
package la_pkg;

  localparam logic [2:0] COND_IGNORE = 3'b000;
  localparam logic [2:0] COND_LOW    = 3'b001;
  localparam logic [2:0] COND_HIGH   = 3'b010;
  localparam logic [2:0] COND_RISE   = 3'b011;
  localparam logic [2:0] COND_FALL   = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CAPTURE,
    ST_HOLDOFF
  } la_state_t;

  // One channel's pattern condition; unknown codes behave as ignore.
  function automatic logic cond_met(input logic [2:0] code, input logic cur,
                                    input logic prev, input logic hist_ok);
    logic r;
    case (code)
      COND_LOW:  r = ~cur;
      COND_HIGH: r = cur;
      COND_RISE: r = hist_ok & ~prev & cur;
      COND_FALL: r = hist_ok & prev & ~cur;
      default:   r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/la_edge_history.sv
module la_edge_history #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_in,
  input  logic           arm_pulse,
  output logic [NCH-1:0] hist,
  output logic           hist_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist       <= '0;
      hist_valid <= 1'b0;
    end else begin
      hist       <= ch_in;
      hist_valid <= ~arm_pulse;
    end
  end

  // R4: arming always leaves the history invalid for the next cycle
  a_r4_hist_cleared : assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse |=> !hist_valid);

endmodule

// File: rtl/la_trigger_eval.sv
module la_trigger_eval #(
  parameter int NCH = 16,
  parameter int CW  = 3,
  localparam int SELW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ch_in,
  input  logic [NCH-1:0]  hist,
  input  logic            hist_valid,
  input  logic            cfg_pattern_mode,
  input  logic [SELW-1:0] cfg_edge_src,
  input  logic            cfg_edge_falling,
  input  logic [NCH*CW-1:0] cfg_cond,
  output logic            trig
);

  logic [NCH-1:0] met;
  logic cur_s, prev_s, edge_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign met[i] = la_pkg::cond_met(cfg_cond[CW*i +: CW], ch_in[i], hist[i],
                                     hist_valid);
  end

  always_comb begin
    cur_s    = ch_in[cfg_edge_src];
    prev_s   = hist[cfg_edge_src];
    edge_hit = hist_valid & (cfg_edge_falling ? (prev_s & ~cur_s)
                                              : (~prev_s & cur_s));
    trig     = cfg_pattern_mode ? (&met) : edge_hit;
  end

  // R4: no edge-mode trigger while history is invalid
  a_r4_no_first_edge : assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pattern_mode && !hist_valid) |-> !trig);

  // R2: an edge trigger needs the source channel to differ from its history
  a_r2_edge_changes : assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pattern_mode && trig) |-> (ch_in[cfg_edge_src] != hist[cfg_edge_src]));

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl #(
  parameter int DEPTH  = 256,
  parameter int HOLD_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  input  logic              cmd_run,
  input  logic              cmd_single,
  input  logic              cmd_stop,
  input  logic              cmd_clear,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              cap_start,
  output logic              done_set,
  output logic              arm_pulse,
  output logic              armed,
  output logic              done
);
  import la_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  la_state_t         state, state_nxt;
  logic              run_mode;
  logic [AW-1:0]     wptr;
  logic [HOLD_W-1:0] hcnt;
  logic              abort;

  always_comb begin
    abort     = cmd_stop | cmd_clear;
    cap_start = (state == ST_ARMED) && trig && !abort;
    done_set  = (state == ST_CAPTURE) && (wptr == LAST) && !abort;
    wr_en     = cap_start || ((state == ST_CAPTURE) && !abort);
    wr_addr   = (state == ST_CAPTURE) ? wptr : '0;
    state_nxt = state;
    if (abort) begin
      state_nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (cmd_run || cmd_single) state_nxt = ST_ARMED;
        ST_ARMED:   if (trig) state_nxt = ST_CAPTURE;
        ST_CAPTURE: if (wptr == LAST) state_nxt = run_mode ? ST_HOLDOFF : ST_IDLE;
        ST_HOLDOFF: if (hcnt == '0) state_nxt = ST_ARMED;
        default:    state_nxt = ST_IDLE;
      endcase
    end
    arm_pulse = (state_nxt == ST_ARMED) && (state != ST_ARMED);
    armed     = (state == ST_ARMED);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      run_mode <= 1'b0;
      wptr     <= '0;
      hcnt     <= '0;
      done     <= 1'b0;
    end else begin
      state <= state_nxt;
      if (state == ST_IDLE && !abort && (cmd_run || cmd_single))
        run_mode <= cmd_run;
      if (cap_start)
        wptr <= AW'(1);
      else if (state == ST_CAPTURE)
        wptr <= wptr + AW'(1);
      if (done_set)
        hcnt <= cfg_holdoff;
      else if (state == ST_HOLDOFF && hcnt != '0)
        hcnt <= hcnt - HOLD_W'(1);
      if (cmd_clear || cap_start)
        done <= 1'b0;
      else if (done_set)
        done <= 1'b1;
    end
  end

  // R5: the write of the last index raises done one edge later
  a_r5_done_after_last : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LAST && !abort) |=> done);

  // R9: a stop or clear always lands in idle
  a_r9_stop_idle : assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == ST_IDLE));

  // R7: no write is ever made while holding off
  a_r7_holdoff_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLDOFF) |-> !cap_start);

  // R11: run/single outside idle do not change the repeat setting
  a_r11_mode_locked : assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(run_mode));

endmodule

// File: rtl/la_capture_mem.sv
module la_capture_mem #(
  parameter int NCH   = 16,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [NCH-1:0] wr_data,
  input  logic           restart,
  input  logic           done_set,
  input  logic           clear,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [NCH-1:0] rd_data,
  output logic           rd_last
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [NCH-1:0] buf_q [DEPTH];
  logic [AW-1:0]  rptr;
  logic           open_q;

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rptr   <= '0;
    end else if (clear || restart) begin
      open_q <= 1'b0;
      rptr   <= '0;
    end else if (done_set) begin
      open_q <= 1'b1;
      rptr   <= '0;
    end else if (open_q && rd_ready) begin
      rptr <= rptr + AW'(1);
      if (rptr == LAST) open_q <= 1'b0;
    end
  end

  always_comb begin
    rd_valid = open_q;
    rd_data  = buf_q[rptr];
    rd_last  = open_q && (rptr == LAST);
  end

  // R6: beat held steady under back-pressure
  a_r6_hold_data : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !restart && !clear) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_last)));

  // R10: clear closes the stream
  a_r10_clear_closes : assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !rd_valid);

  // R6: the stream ends after the last beat is taken
  a_r6_end_after_last : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_last && rd_ready && !done_set) |=> !rd_valid);

endmodule

// File: rtl/la_trigger_capture.sv
module la_trigger_capture #(
  parameter int NCH    = 16,
  parameter int DEPTH  = 256,
  parameter int HOLD_W = 16,
  parameter int CW     = 3,
  localparam int SELW = $clog2(NCH),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_in,
  input  logic              cfg_pattern_mode,
  input  logic [SELW-1:0]   cfg_edge_src,
  input  logic              cfg_edge_falling,
  input  logic [NCH*CW-1:0] cfg_cond,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  input  logic              cmd_run,
  input  logic              cmd_single,
  input  logic              cmd_stop,
  input  logic              cmd_clear,
  output logic              armed,
  output logic              done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [NCH-1:0]    rd_data,
  output logic              rd_last
);

  logic [NCH-1:0] hist;
  logic           hist_valid, trig, arm_pulse;
  logic           wr_en, cap_start, done_set;
  logic [AW-1:0]  wr_addr;

  la_edge_history #(.NCH(NCH)) u_hist (
    .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .arm_pulse(arm_pulse),
    .hist(hist), .hist_valid(hist_valid)
  );

  la_trigger_eval #(.NCH(NCH), .CW(CW)) u_eval (
    .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .hist(hist),
    .hist_valid(hist_valid), .cfg_pattern_mode(cfg_pattern_mode),
    .cfg_edge_src(cfg_edge_src), .cfg_edge_falling(cfg_edge_falling),
    .cfg_cond(cfg_cond), .trig(trig)
  );

  la_capture_ctrl #(.DEPTH(DEPTH), .HOLD_W(HOLD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_holdoff(cfg_holdoff),
    .cmd_run(cmd_run), .cmd_single(cmd_single), .cmd_stop(cmd_stop),
    .cmd_clear(cmd_clear), .wr_en(wr_en), .wr_addr(wr_addr),
    .cap_start(cap_start), .done_set(done_set), .arm_pulse(arm_pulse),
    .armed(armed), .done(done)
  );

  la_capture_mem #(.NCH(NCH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(ch_in), .restart(cap_start), .done_set(done_set),
    .clear(cmd_clear), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  // R1: the stream is never open without a stored frame
  a_r1_valid_needs_done : assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);

endmodule

// File: tb/tb_la_trigger_capture.sv
`timescale 1ns/1ps
module tb_la_trigger_capture;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ch_in;
  logic        cfg_pattern_mode, cfg_edge_falling;
  logic [3:0]  cfg_edge_src;
  logic [47:0] cfg_cond;
  logic [15:0] cfg_holdoff;
  logic        cmd_run, cmd_single, cmd_stop, cmd_clear;
  logic        armed, done, rd_valid, rd_ready, rd_last;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_buf [256];

  always #4 clk = ~clk;

  la_trigger_capture dut (
    .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .cfg_pattern_mode(cfg_pattern_mode),
    .cfg_edge_src(cfg_edge_src), .cfg_edge_falling(cfg_edge_falling),
    .cfg_cond(cfg_cond), .cfg_holdoff(cfg_holdoff), .cmd_run(cmd_run),
    .cmd_single(cmd_single), .cmd_stop(cmd_stop), .cmd_clear(cmd_clear),
    .armed(armed), .done(done), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  // {pattern_mode, edge_src[4], falling, cond[48], pre[16], trig[16], fires}
  localparam int NV = 10;
  localparam logic [86:0] VEC [NV] = '{
    {1'b0, 4'd3,  1'b0, 48'h0,              16'h0000, 16'h0008, 1'b1},
    {1'b0, 4'd3,  1'b0, 48'h0,              16'h0008, 16'h0000, 1'b0},
    {1'b0, 4'd15, 1'b1, 48'h0,              16'h8000, 16'h0000, 1'b1},
    {1'b0, 4'd5,  1'b0, 48'h0,              16'h0000, 16'hFFDF, 1'b0},
    {1'b1, 4'd0,  1'b0, 48'h0000_0000_00CA, 16'h0001, 16'h0005, 1'b1},
    {1'b1, 4'd0,  1'b0, 48'h0000_0000_00CA, 16'h0001, 16'h0007, 1'b0},
    {1'b1, 4'd0,  1'b0, 48'h8000_0200_0000, 16'h8100, 16'h0100, 1'b1},
    {1'b1, 4'd0,  1'b0, 48'h0000_001C_5002, 16'h0000, 16'h0001, 1'b1},
    {1'b1, 4'd0,  1'b0, 48'h0000_2060_0000, 16'h0200, 16'h0080, 1'b1},
    {1'b1, 4'd0,  1'b0, 48'h0000_2060_0000, 16'h0200, 16'h0280, 1'b0}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    step(1);
    sig = 1'b0;
  endtask

  // R6: drain a whole frame, holding one beat under back-pressure
  task automatic drain_frame();
    for (int i = 0; i < 256; i++) begin
      chk("R6 rd_valid", {31'd0, rd_valid}, 32'd1);
      chk("R6 rd_data", {16'd0, rd_data}, {16'd0, exp_buf[i]});
      chk("R6 rd_last", {31'd0, rd_last}, {31'd0, (i == 255)});
      if (i == 7) begin
        step(1);
        chk("R6 held data", {16'd0, rd_data}, {16'd0, exp_buf[i]});
      end
      rd_ready = 1'b1;
      step(1);
      rd_ready = 1'b0;
    end
    chk("R6 stream closed", {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    rst_n = 1'b0; ch_in = '0; cfg_pattern_mode = 1'b0; cfg_edge_src = '0;
    cfg_edge_falling = 1'b0; cfg_cond = '0; cfg_holdoff = '0;
    cmd_run = 0; cmd_single = 0; cmd_stop = 0; cmd_clear = 0; rd_ready = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 armed", {31'd0, armed}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 rd_last", {31'd0, rd_last}, 32'd0);

    // Vector table walk: R2 edge, R3 pattern, R5 capture, R6 read, R8 single
    for (int v = 0; v < NV; v++) begin
      logic [86:0] e;
      e = VEC[v];
      cfg_pattern_mode = e[86];
      cfg_edge_src     = e[85:82];
      cfg_edge_falling = e[81];
      cfg_cond         = e[80:33];
      ch_in            = e[32:17];
      pulse(cmd_single);
      chk(e[86] ? "R3 armed" : "R2 armed", {31'd0, armed}, 32'd1);
      step(1);
      ch_in = e[16:1];
      exp_buf[0] = e[16:1];
      step(1);
      chk(e[86] ? "R3 trigger" : "R2 trigger", {31'd0, armed}, {31'd0, !e[0]});
      if (e[0]) begin
        for (int k = 1; k < 256; k++) begin
          logic [15:0] s;
          s = 16'(k * 41925 + v * 257);
          ch_in = s;
          exp_buf[k] = s;
          if (k == 255) chk("R5 done early", {31'd0, done}, 32'd0);
          step(1);
        end
        chk("R5 done", {31'd0, done}, 32'd1);
        chk("R8 single idle", {31'd0, armed}, 32'd0);
        drain_frame();
        step(3);
        chk("R8 single stays idle", {31'd0, armed}, 32'd0);
      end else begin
        pulse(cmd_stop);
      end
    end

    // R4: change on the first armed sample must not fire an edge trigger
    cfg_pattern_mode = 1'b0; cfg_edge_src = 4'd0; cfg_edge_falling = 1'b0;
    ch_in = 16'h0000;
    cmd_single = 1'b1;
    step(1);
    cmd_single = 1'b0;
    ch_in = 16'h0001;
    step(1);
    chk("R4 no first-sample edge", {31'd0, armed}, 32'd1);
    step(2);
    chk("R4 still armed", {31'd0, armed}, 32'd1);
    pulse(cmd_stop);

    // R7/R8/R11: run mode with all-ignore pattern and holdoff 3
    cfg_pattern_mode = 1'b1; cfg_cond = '0; cfg_holdoff = 16'd3;
    pulse(cmd_run);
    chk("R8 run armed", {31'd0, armed}, 32'd1);
    step(1);
    chk("R3 all ignore fires", {31'd0, armed}, 32'd0);
    pulse(cmd_single);
    step(254);
    chk("R5 run done", {31'd0, done}, 32'd1);
    step(3);
    chk("R7 holdoff not armed", {31'd0, armed}, 32'd0);
    chk("R7 holdoff keeps frame", {31'd0, done}, 32'd1);
    step(1);
    chk("R7 re-armed", {31'd0, armed}, 32'd1);
    step(1);
    chk("R8 run recaptures", {31'd0, armed}, 32'd0);
    chk("R11 single ignored, new frame", {31'd0, done}, 32'd0);

    // R9: stop during capture
    pulse(cmd_stop);
    chk("R9 stop idle", {31'd0, armed}, 32'd0);
    chk("R9 stop in capture done", {31'd0, done}, 32'd0);
    chk("R9 stop stream", {31'd0, rd_valid}, 32'd0);
    step(5);
    chk("R9 no capture after stop", {31'd0, armed}, 32'd0);

    // R7 zero holdoff
    cfg_holdoff = 16'd0;
    pulse(cmd_run);
    step(1);
    chk("R8 run fired", {31'd0, armed}, 32'd0);
    step(255);
    chk("R5 done zero holdoff", {31'd0, done}, 32'd1);
    cfg_cond = 48'h2;
    ch_in = 16'h0000;
    step(1);
    chk("R7 zero holdoff re-arm", {31'd0, armed}, 32'd1);
    step(1);
    chk("R3 unmet pattern", {31'd0, armed}, 32'd1);

    // R9: stop while armed keeps frame
    pulse(cmd_stop);
    chk("R9 stop armed idle", {31'd0, armed}, 32'd0);
    chk("R9 keeps done", {31'd0, done}, 32'd1);
    chk("R9 keeps stream", {31'd0, rd_valid}, 32'd1);

    // R10: clear
    pulse(cmd_clear);
    chk("R10 done cleared", {31'd0, done}, 32'd0);
    chk("R10 stream closed", {31'd0, rd_valid}, 32'd0);

    // R11: clear beats run in the same cycle
    cmd_run = 1'b1;
    pulse(cmd_clear);
    cmd_run = 1'b0;
    chk("R11 clear over run", {31'd0, armed}, 32'd0);
    // R11: stop beats single in the same cycle
    cmd_single = 1'b1;
    pulse(cmd_stop);
    cmd_single = 1'b0;
    chk("R11 stop over single", {31'd0, armed}, 32'd0);

    // R10: restart after clear
    pulse(cmd_single);
    chk("R10 restart armed", {31'd0, armed}, 32'd1);
    ch_in = 16'h0001;
    step(1);
    chk("R10 restart fires", {31'd0, armed}, 32'd0);
    step(255);
    chk("R10 restart done", {31'd0, done}, 32'd1);
    chk("R10 restart stream", {31'd0, rd_valid}, 32'd1);
    chk("R10 index0 sample", {16'd0, rd_data}, 32'h0001);

    report();
  end

endmodule